// File: doc/BRIEF.md
# Serial Converter Host Controller

This block is the host-side master for a serial 8-bit analog-to-digital converter. A one-cycle request carries a channel configuration: a single/differential bit and an odd/sign bit. When the block accepts the request, it pulls chip select low. It then produces a serial clock by dividing the system clock by `DIV`, and shifts a start bit and the two configuration bits onto the data pin. The converter samples these bits on its rising clock edges.

After the address, the block stops driving the data pin. One bidirectional wire can therefore carry both directions. The block skips the converter's settling slot, which is nominally zero. It then captures eight result bits sent MSB first, followed by seven echo bits sent LSB first. The echo bits repeat bits 1 to 7 of the result; bit 0 is shared by both streams and is not sent twice.

At the end of the frame, chip select returns high. The block then pulses `done`, presents the result, and raises `mismatch` if the echo disagrees with the result.

Top module: `adc_serial_host`

The frame state machine has six states:
- `ST_IDLE` moves to `ST_ADDR` on a request.
- `ST_ADDR` moves to `ST_ZERO` after three periods.
- `ST_ZERO` moves to `ST_MSB` after one period.
- `ST_MSB` moves to `ST_LSB` after `DW` periods.
- `ST_LSB` moves to `ST_CLOSE` after `DW-1` periods.
- `ST_CLOSE` moves back to `ST_IDLE` after one cycle.

## Requirements
- R1: During and right after reset, `spi_cs_n` is 1, and `spi_sclk`, `sd_oe`, `done` and `busy` are 0.
- R2: An accepted request keeps `spi_cs_n` low for exactly 19 rising edges of `spi_sclk`: 3 address, 1 settling, 8 result and 7 echo periods. It returns high as the last high phase ends.
- R3: `spi_sclk` is 0 whenever `spi_cs_n` is 1. Inside a frame, each period lasts `DIV` clocks, with `DIV/2` clocks low followed by `DIV/2` clocks high. `DIV` is even and at least 4.
- R4: During periods 1 to 3, `sd_oe` is 1 and `sd_out` carries 1, then `req_single`, then `req_odd`. The value is set at the start of each low phase and held through the high phase.
- R5: `sd_oe` drops at the falling edge that ends period 3. It stays 0 until `spi_cs_n` rises, so the block never drives the pin while the converter answers.
- R6: The block samples `sd_in` once, in the middle of each high phase. Periods 5 to 12 give `result[7]` down to `result[0]`. The value on the pin in period 4 has no effect.
- R7: Periods 13 to 19 carry result bits 1, 2, …, 7 in that order. `mismatch` is 1 exactly when any of them differs from the matching bit of the result.
- R8: `done` is a one-cycle pulse in the clock after `spi_cs_n` rises. `result` and `mismatch` take their new values with it and hold them until the next pulse.
- R9: A request that arrives while `busy` is 1 has no effect. The running frame is unchanged and no further frame follows it.
- R10: `busy` is 1 from the clock after an accepted request until the frame closes. It is 0 when `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-cycle conversion request, accepted only when idle |
| req_single | input | 1 | Single-ended (1) or differential (0) selection |
| req_odd | input | 1 | Odd channel or sign selection |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse when a frame completes |
| result | output | DW | Converted value, MSB-first capture |
| mismatch | output | 1 | The echo stream disagreed with the result |
| spi_cs_n | output | 1 | Active-low chip select to the converter |
| spi_sclk | output | 1 | Serial clock to the converter |
| sd_out | output | 1 | Value the block drives on the shared data pin |
| sd_oe | output | 1 | Enable for `sd_out` onto the shared pin |
| sd_in | input | 1 | Value read back from the shared data pin |

## Verification
The bench uses a behavioural converter that answers on falling edges and watches the shared pin for double drive. A design that released the pin one period late would collide with the settling slot. Releasing it one period early would lose the odd bit.

One frame puts a 1 in the settling slot. A design that counted that slot as data would shift every result bit by one position.

Other frames flip the first or the last echo bit. A design that paired the echo with the wrong bits, or ignored the echo, would leave `mismatch` low. A clean 0xFF or 0x00 would then show it set falsely.

A request issued in the middle of a frame catches a controller that restarts or queues a second frame.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ZERO,
        ST_MSB,
        ST_LSB,
        ST_CLOSE
    } host_state_e;

    // start bit + single/diff bit + odd/sign bit
    localparam int ADDR_SLOTS = 3;

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic prd_end,
    output logic smp
);
    localparam int HALF = DIV / 2;
    localparam int MID  = HALF + HALF / 2;
    localparam int CW   = $clog2(DIV);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;
    logic          sclk_q;

    always_comb begin
        if (cnt_q == CW'(DIV - 1)) begin
            cnt_nxt = '0;
        end else begin
            cnt_nxt = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (!run) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_nxt;
            sclk_q <= (cnt_nxt >= CW'(HALF));
        end
    end

    assign sclk    = sclk_q;
    assign prd_end = run && (cnt_q == CW'(DIV - 1));
    assign smp     = run && (cnt_q == CW'(MID));

endmodule

// File: rtl/adc_rx_capture.sv
module adc_rx_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_word,
    input  logic          shift_echo,
    input  logic          sd_in,
    output logic [DW-1:0] word,
    output logic          echo_ok
);
    logic [DW-1:0] word_q;
    logic [DW-2:0] echo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            echo_q <= '0;
        end else begin
            if (shift_word) begin
                word_q <= {word_q[DW-2:0], sd_in};
            end
            if (shift_echo) begin
                // first echo bit is word bit 1; it ends up at echo_q[0]
                echo_q <= {sd_in, echo_q[DW-2:1]};
            end
        end
    end

    assign word    = word_q;
    assign echo_ok = (echo_q == word_q[DW-1:1]);

endmodule

// File: rtl/adc_serial_host.sv
module adc_serial_host
    import adc_host_pkg::*;
#(
    parameter int DIV = 8,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_single,
    input  logic          req_odd,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] result,
    output logic          mismatch,
    output logic          spi_cs_n,
    output logic          spi_sclk,
    output logic          sd_out,
    output logic          sd_oe,
    input  logic          sd_in
);
    localparam int BCW = $clog2(DW);

    host_state_e   state_q, state_d;
    logic [BCW-1:0] bit_q;
    logic          cs_n_q;
    logic          sd_out_q;
    logic          sd_oe_q;
    logic          sgl_q;
    logic          odd_q;
    logic          done_q;
    logic          mism_q;
    logic [DW-1:0] result_q;

    logic          prd_end;
    logic          smp;
    logic [DW-1:0] word;
    logic          echo_ok;

    adc_sclk_gen #(
        .DIV (DIV)
    ) i_sclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (!cs_n_q),
        .sclk    (spi_sclk),
        .prd_end (prd_end),
        .smp     (smp)
    );

    adc_rx_capture #(
        .DW (DW)
    ) i_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_word (smp && (state_q == ST_MSB)),
        .shift_echo (smp && (state_q == ST_LSB)),
        .sd_in      (sd_in),
        .word       (word),
        .echo_ok    (echo_ok)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req) state_d = ST_ADDR;
            ST_ADDR:  if (prd_end && bit_q == BCW'(ADDR_SLOTS - 1)) state_d = ST_ZERO;
            ST_ZERO:  if (prd_end) state_d = ST_MSB;
            ST_MSB:   if (prd_end && bit_q == BCW'(DW - 1)) state_d = ST_LSB;
            ST_LSB:   if (prd_end && bit_q == BCW'(DW - 2)) state_d = ST_CLOSE;
            ST_CLOSE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q   <= 1'b1;
            sd_out_q <= 1'b0;
            sd_oe_q  <= 1'b0;
            bit_q    <= '0;
            sgl_q    <= 1'b0;
            odd_q    <= 1'b0;
            done_q   <= 1'b0;
            mism_q   <= 1'b0;
            result_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (state_q == ST_IDLE && req) begin
                cs_n_q   <= 1'b0;
                sd_oe_q  <= 1'b1;
                sd_out_q <= 1'b1;
                sgl_q    <= req_single;
                odd_q    <= req_odd;
                bit_q    <= '0;
            end
            if (prd_end) begin
                if (state_d != state_q) begin
                    bit_q <= '0;
                end else begin
                    bit_q <= bit_q + 1'b1;
                end
                if (state_q == ST_ADDR) begin
                    if (bit_q == BCW'(0)) begin
                        sd_out_q <= sgl_q;
                    end else if (bit_q == BCW'(1)) begin
                        sd_out_q <= odd_q;
                    end else begin
                        sd_out_q <= 1'b0;
                        sd_oe_q  <= 1'b0;
                    end
                end
                if (state_q == ST_LSB && state_d == ST_CLOSE) begin
                    cs_n_q <= 1'b1;
                end
            end
            if (state_q == ST_CLOSE) begin
                done_q   <= 1'b1;
                result_q <= word;
                mism_q   <= !echo_ok;
            end
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign result   = result_q;
    assign mismatch = mism_q;
    assign spi_cs_n = cs_n_q;
    assign sd_out   = sd_out_q;
    assign sd_oe    = sd_oe_q;

endmodule

// File: rtl/adc_host_checker.sv
module adc_host_checker (
    input logic clk,
    input logic rst_n,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic sd_out,
    input logic sd_oe,
    input logic busy,
    input logic done
);

    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk) else $error("sclk active while deselected"); // R3

    AST_ADDR_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(sd_out)) else $error("data moved during high phase"); // R4

    AST_PIN_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        sd_oe |-> !spi_cs_n) else $error("pin driven outside frame"); // R5

    AST_NO_REDRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && $past(!spi_cs_n) && $past(!sd_oe)) |-> !sd_oe) else $error("pin driven again after release"); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R8

    AST_DONE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> spi_cs_n) else $error("done inside frame"); // R8

    AST_BUSY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy) else $error("not busy inside frame"); // R10

    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy) else $error("busy with done"); // R10

endmodule

bind adc_serial_host adc_host_checker i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_cs_n (spi_cs_n),
    .spi_sclk (spi_sclk),
    .sd_out   (sd_out),
    .sd_oe    (sd_oe),
    .busy     (busy),
    .done     (done)
);

// File: tb/test_adc_serial_host.sv
`timescale 1ns/1ps
module test_adc_serial_host;
    localparam int DIV = 8;
    localparam int DW  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, req_single = 1'b0, req_odd = 1'b0;
    logic busy, done, mismatch, spi_cs_n, spi_sclk, sd_out, sd_oe;
    logic [DW-1:0] result;
    logic cv_oe = 1'b0, cv_do = 1'b0;
    wire  sd_pin = sd_oe ? sd_out : (cv_oe ? cv_do : 1'b1);

    always #4 clk = ~clk;

    adc_serial_host #(.DIV(DIV), .DW(DW)) i_adc_serial_host (
        .clk(clk), .rst_n(rst_n), .req(req), .req_single(req_single),
        .req_odd(req_odd), .busy(busy), .done(done), .result(result),
        .mismatch(mismatch), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_pin)
    );

    int n_tests = 0, n_fail = 0, n_done = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // converter model
    logic [7:0] cv_val = 8'h00;
    logic [6:0] cv_flip = 7'h00;
    logic       cv_lead = 1'b0;
    logic       exp_sgl = 1'b0, exp_odd = 1'b0;
    int rise_n = 0, fall_n = 0, per_err = 0, addr_err = 0, oe_err = 0, clash = 0;
    int cyc = 0, last_rise = 0;

    always @(posedge clk) cyc++;

    always @(negedge spi_cs_n) begin
        rise_n = 0; fall_n = 0; per_err = 0; addr_err = 0; oe_err = 0; clash = 0;
    end

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            rise_n++;
            if (rise_n > 1 && cyc - last_rise != DIV) per_err++;
            last_rise = cyc;
            if (rise_n <= 3 && !sd_oe) oe_err++;
            if (rise_n > 3 && sd_oe) oe_err++;
            if (rise_n == 1 && sd_pin !== 1'b1) addr_err++;
            if (rise_n == 2 && sd_pin !== exp_sgl) addr_err++;
            if (rise_n == 3 && sd_pin !== exp_odd) addr_err++;
        end
    end

    always @(negedge spi_sclk) begin
        if (!spi_cs_n) begin
            fall_n++;
            if (cyc - last_rise != DIV / 2) per_err++;
            if (fall_n == 3) begin
                cv_oe = 1'b1; cv_do = cv_lead;
            end else if (fall_n >= 4 && fall_n <= 11) begin
                cv_do = cv_val[11 - fall_n];
            end else if (fall_n >= 12 && fall_n <= 18) begin
                cv_do = cv_val[fall_n - 11] ^ cv_flip[fall_n - 12];
            end
        end
    end

    always @(posedge spi_cs_n) begin
        cv_oe = 1'b0;
        if (rst_n) begin
            chk(rise_n == 19, "R2", "rising edges per frame", rise_n, 19);
            chk(per_err == 0, "R3", "period/phase errors", per_err, 0);
            chk(addr_err == 0, "R4", "address bit errors", addr_err, 0);
            chk(oe_err == 0, "R5", "pin enable errors", oe_err, 0);
            chk(clash == 0, "R5", "pin double drive", clash, 0);
        end
    end

    always @(negedge clk) if (sd_oe && cv_oe) clash++;

    // scoreboard
    typedef struct packed { logic [7:0] res; logic mis; } exp_t;
    exp_t sb_q[$];

    always @(negedge clk) begin
        if (rst_n && done) begin
            n_done++;
            chk(!busy, "R10", "busy at done", busy, 0);
            if (sb_q.size() == 0) begin
                chk(1'b0, "R9", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(result == e.res, "R6", "result", result, e.res);
                chk(mismatch == e.mis, "R7", "mismatch", mismatch, e.mis);
            end
        end
    end

    task automatic xfer(input logic [7:0] val, input logic sgl, input logic odd,
                        input logic [6:0] flip, input logic lead, input bit poke);
        exp_t e;
        cv_val = val; cv_flip = flip; cv_lead = lead;
        exp_sgl = sgl; exp_odd = odd;
        e.res = val; e.mis = (flip != 7'h00);
        sb_q.push_back(e);
        @(negedge clk);
        req = 1'b1; req_single = sgl; req_odd = odd;
        @(negedge clk);
        req = 1'b0; req_single = ~sgl; req_odd = ~odd;
        chk(busy == 1'b1, "R10", "busy after accept", busy, 1);
        if (poke) begin
            // R9: request mid-frame with another configuration
            repeat (5 * DIV) @(negedge clk);
            req = 1'b1;
            @(negedge clk);
            req = 1'b0;
        end
        while (!done) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(result == val, "R8", "result held after done", result, val);
        chk(mismatch == e.mis, "R8", "mismatch held after done", mismatch, e.mis);
        if (poke) begin
            repeat (3 * DIV) @(negedge clk);
            chk(spi_cs_n == 1'b1 && !busy, "R9", "no frame after ignored request",
                {spi_cs_n, busy}, 2'b10);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0 && sd_oe == 1'b0 && !done && !busy,
            "R1", "reset outputs", {spi_cs_n, spi_sclk, sd_oe, done, busy}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0 && !busy, "R1", "after reset",
            {spi_cs_n, spi_sclk, busy}, 3'b100);
        xfer(8'hA5, 1'b1, 1'b0, 7'h00, 1'b0, 1'b0);
        xfer(8'h00, 1'b0, 1'b1, 7'h00, 1'b0, 1'b0);
        xfer(8'hFF, 1'b1, 1'b1, 7'h00, 1'b0, 1'b0);
        xfer(8'h5A, 1'b0, 1'b0, 7'h00, 1'b1, 1'b0); // R6 settling slot carries 1
        xfer(8'h3C, 1'b0, 1'b0, 7'h01, 1'b0, 1'b0); // R7 first echo bit wrong
        xfer(8'h81, 1'b1, 1'b0, 7'h40, 1'b0, 1'b0); // R7 last echo bit wrong
        xfer(8'h69, 0, 1, 7'h00, 1'b0, 1'b1);       // R9 request while busy
        chk(n_done == 7, "R9", "done pulse count", n_done, 7);
        chk(sb_q.size() == 0, "R8", "scoreboard drained", sb_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule